// File: doc/BRIEF.md
# Dual-Issue Pair Selector

This block decides, once per clock, how many of two fetched instructions may leave the front end of a two-wide in-order pipeline. The fetch unit presents the two oldest unissued instructions, each already decoded into an instruction class, an optional destination and up to three optional source specifiers. The older instruction sits in the first slot, which feeds the integer pipe. The younger sits in the second slot, which feeds the floating-point pipe. The block answers with zero, one or two issue grants. Fetch then advances by that count, so an instruction that did not issue shows up again next cycle as the older instruction.

Pairing is deliberately simple. The second slot issues only together with the first, and only when the first is an integer-pipe class and the second is a floating-point operation. It also needs no register dependence on its partner. Loads, including floating-point loads that travel down the integer pipe, mark their destination busy in a small per-register scoreboard. This covers the load-use delay: the partner of a load and the whole pair that follows cannot consume the loaded value.

Top module: `dual_issue_pair`

## Requirements
- R1: The first slot issues exactly when its valid bit is set and none of its enabled sources is busy in the scoreboard. An invalid first slot issues nothing.
- R2: The second slot never issues in a cycle in which the first slot does not issue, including when the first slot is invalid.
- R3: Class codes are 0 integer ALU, 1 integer load, 2 floating-point load, 3 floating-point operation. The second slot issues only when the first holds class 0, 1 or 2 and the second holds class 3. In any other mix only the first may issue.
- R4: A floating-point load in the first slot pairs with a floating-point operation in the second when there is no dependence between them.
- R5: The second slot does not issue when any of its enabled sources equals the enabled destination of the first-slot instruction in the same pair.
- R6: A load issued in cycle t makes its destination busy for the next LOAD_DELAY cycles (default 1). No instruction that reads that register issues in those cycles, and the register is free afterwards.
- R7: A source specifier whose enable bit is clear is never compared, whatever register number it carries.
- R8: After reset no register is busy, so a pair reading any registers issues in full.
- R9: Only loads mark registers busy. A non-load writer does not delay a reader in the following cycle.
- R10: A register id is 4 bits. Bit 3 selects the file (0 integer, 1 floating point) and bits 2:0 the index. Equal indices in different files do not conflict.
- R11: issue_cnt equals the number of grants given in the cycle (0, 1 or 2).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| a_vld | input | 1 | First (older) slot holds an instruction |
| a_kind | input | 2 | First slot class code |
| a_dst_en | input | 1 | First slot writes a register |
| a_dst | input | 4 | First slot destination id |
| a_src_en | input | 3 | First slot source enables |
| a_src | input | 12 | First slot source ids, source k in bits 4k+3:4k |
| b_vld | input | 1 | Second (younger) slot holds an instruction |
| b_kind | input | 2 | Second slot class code |
| b_src_en | input | 3 | Second slot source enables |
| b_src | input | 12 | Second slot source ids, same packing |
| issue_a | output | 1 | First slot issues this cycle |
| issue_b | output | 1 | Second slot issues this cycle |
| issue_cnt | output | 2 | Instructions consumed this cycle |

## Verification
The assertions assume the fetch unit keeps program order. They also assume a register id presented with its enable set is a real register, and that LOAD_DELAY is at least one. The load-use property keys off the previous cycle's issued load only. The bench keeps to these assumptions by building every pair from the four legal class codes and in-range ids. It drives a fresh pair each cycle from its own model, so nothing relies on the design holding instructions. The random phase draws from a pool of four registers split across both files, so that same-pair, load-use and cross-file collisions occur often.

// File: rtl/dip_pkg.sv
package dip_pkg;

    typedef enum logic [1:0] {
        KIND_ALU = 2'd0,
        KIND_LDI = 2'd1,
        KIND_LDF = 2'd2,
        KIND_FOP = 2'd3
    } kind_e;

    typedef struct packed {
        logic first;
        logic second;
    } grant_t;

    function automatic logic kind_is_load(kind_e k);
        return (k == KIND_LDI) || (k == KIND_LDF);
    endfunction

    function automatic logic kind_int_pipe(kind_e k);
        return k != KIND_FOP;
    endfunction

endpackage

// File: rtl/dip_scoreboard.sv
module dip_scoreboard #(
    parameter int NREGS      = 16,
    parameter int REG_W      = 4,
    parameter int LOAD_DELAY = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             set_en,
    input  logic [REG_W-1:0] set_reg,
    output logic [NREGS-1:0] busy
);
    localparam int CNT_W = (LOAD_DELAY < 1) ? 1 : $clog2(LOAD_DELAY + 1);

    for (genvar r = 0; r < NREGS; r++) begin : g_reg
        logic [CNT_W-1:0] left_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                left_q <= '0;
            end else if (set_en && (set_reg == REG_W'(r))) begin
                left_q <= CNT_W'(LOAD_DELAY);
            end else if (left_q != '0) begin
                left_q <= left_q - CNT_W'(1);
            end
        end
        assign busy[r] = (left_q != '0);
    end
endmodule

// File: rtl/dip_src_match.sv
module dip_src_match #(
    parameter int NREGS = 16,
    parameter int REG_W = 4,
    parameter int NSRC  = 3
) (
    input  logic [NSRC-1:0]       src_en,
    input  logic [NSRC*REG_W-1:0] src,
    input  logic [NREGS-1:0]      busy,
    input  logic                  prod_en,
    input  logic [REG_W-1:0]      prod_dst,
    output logic                  hit_busy,
    output logic                  hit_prod
);
    logic [NSRC-1:0] per_busy;
    logic [NSRC-1:0] per_prod;

    for (genvar k = 0; k < NSRC; k++) begin : g_src
        logic [REG_W-1:0] id;
        assign id          = src[k*REG_W +: REG_W];
        assign per_busy[k] = src_en[k] && busy[id];
        assign per_prod[k] = src_en[k] && prod_en && (id == prod_dst);
    end

    assign hit_busy = |per_busy;
    assign hit_prod = |per_prod;
endmodule

// File: rtl/dip_pair_rules.sv
module dip_pair_rules
    import dip_pkg::*;
(
    input  logic   a_vld,
    input  kind_e  a_kind,
    input  logic   a_hit_busy,
    input  logic   b_vld,
    input  kind_e  b_kind,
    input  logic   b_hit_busy,
    input  logic   b_hit_a,
    output grant_t grant
);
    logic slot_types_ok;

    always_comb begin
        slot_types_ok = kind_int_pipe(a_kind) && (b_kind == KIND_FOP);
        grant.first   = a_vld && !a_hit_busy;
        grant.second  = grant.first && b_vld && slot_types_ok
                        && !b_hit_busy && !b_hit_a;
    end
endmodule

// File: rtl/dual_issue_pair.sv
module dual_issue_pair
    import dip_pkg::*;
#(
    parameter int NREG_FILE  = 8,
    parameter int NSRC       = 3,
    parameter int LOAD_DELAY = 1,
    localparam int NREGS     = 2 * NREG_FILE,
    localparam int REG_W     = $clog2(NREGS)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  a_vld,
    input  logic [1:0]            a_kind,
    input  logic                  a_dst_en,
    input  logic [REG_W-1:0]      a_dst,
    input  logic [NSRC-1:0]       a_src_en,
    input  logic [NSRC*REG_W-1:0] a_src,
    input  logic                  b_vld,
    input  logic [1:0]            b_kind,
    input  logic [NSRC-1:0]       b_src_en,
    input  logic [NSRC*REG_W-1:0] b_src,
    output logic                  issue_a,
    output logic                  issue_b,
    output logic [1:0]            issue_cnt
);
    logic [NREGS-1:0] busy;
    logic             a_hit_busy, a_hit_unused;
    logic             b_hit_busy, b_hit_a;
    logic             load_set;
    grant_t           grant;

    dip_scoreboard #(.NREGS(NREGS), .REG_W(REG_W), .LOAD_DELAY(LOAD_DELAY)) u_sb (
        .clk     (clk),
        .rst     (rst),
        .set_en  (load_set),
        .set_reg (a_dst),
        .busy    (busy)
    );

    dip_src_match #(.NREGS(NREGS), .REG_W(REG_W), .NSRC(NSRC)) u_match_a (
        .src_en   (a_src_en),
        .src      (a_src),
        .busy     (busy),
        .prod_en  (1'b0),
        .prod_dst (a_dst),
        .hit_busy (a_hit_busy),
        .hit_prod (a_hit_unused)
    );

    dip_src_match #(.NREGS(NREGS), .REG_W(REG_W), .NSRC(NSRC)) u_match_b (
        .src_en   (b_src_en),
        .src      (b_src),
        .busy     (busy),
        .prod_en  (a_dst_en),
        .prod_dst (a_dst),
        .hit_busy (b_hit_busy),
        .hit_prod (b_hit_a)
    );

    dip_pair_rules u_rules (
        .a_vld      (a_vld),
        .a_kind     (kind_e'(a_kind)),
        .a_hit_busy (a_hit_busy),
        .b_vld      (b_vld),
        .b_kind     (kind_e'(b_kind)),
        .b_hit_busy (b_hit_busy),
        .b_hit_a    (b_hit_a),
        .grant      (grant)
    );

    assign load_set  = grant.first && a_dst_en && kind_is_load(kind_e'(a_kind));
    assign issue_a   = grant.first;
    assign issue_b   = grant.second;
    assign issue_cnt = {1'b0, grant.first} + {1'b0, grant.second};

endmodule

// File: rtl/dip_issue_chk.sv
module dip_issue_chk #(
    parameter int REG_W = 4,
    parameter int NSRC  = 3
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  a_vld,
    input logic [1:0]            a_kind,
    input logic                  a_dst_en,
    input logic [REG_W-1:0]      a_dst,
    input logic [NSRC-1:0]       a_src_en,
    input logic [NSRC*REG_W-1:0] a_src,
    input logic                  b_vld,
    input logic [1:0]            b_kind,
    input logic [NSRC-1:0]       b_src_en,
    input logic [NSRC*REG_W-1:0] b_src,
    input logic                  issue_a,
    input logic                  issue_b
);
    logic             prev_ld_q;
    logic [REG_W-1:0] prev_dst_q;
    logic [NSRC-1:0]  b_on_a, a_on_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_ld_q  <= 1'b0;
            prev_dst_q <= '0;
        end else begin
            prev_ld_q  <= issue_a && a_dst_en && (a_kind == 2'd1 || a_kind == 2'd2);
            prev_dst_q <= a_dst;
        end
    end

    for (genvar k = 0; k < NSRC; k++) begin : g_cmp
        assign b_on_a[k]    = b_src_en[k] && (b_src[k*REG_W +: REG_W] == a_dst);
        assign a_on_prev[k] = a_src_en[k] && (a_src[k*REG_W +: REG_W] == prev_dst_q);
    end

    // R1
    a_needs_valid_chk: assert property (@(posedge clk) disable iff (rst)
        issue_a |-> a_vld);

    // R2
    b_needs_a_chk: assert property (@(posedge clk) disable iff (rst)
        issue_b |-> (issue_a && b_vld));

    // R3
    slot_types_chk: assert property (@(posedge clk) disable iff (rst)
        issue_b |-> (a_kind != 2'd3 && b_kind == 2'd3));

    // R5
    pair_raw_chk: assert property (@(posedge clk) disable iff (rst)
        (issue_b && a_dst_en) |-> (b_on_a == '0));

    // R6
    load_use_chk: assert property (@(posedge clk) disable iff (rst)
        (prev_ld_q && issue_a) |-> (a_on_prev == '0));

endmodule

bind dual_issue_pair dip_issue_chk #(.REG_W(REG_W), .NSRC(NSRC)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .a_vld    (a_vld),
    .a_kind   (a_kind),
    .a_dst_en (a_dst_en),
    .a_dst    (a_dst),
    .a_src_en (a_src_en),
    .a_src    (a_src),
    .b_vld    (b_vld),
    .b_kind   (b_kind),
    .b_src_en (b_src_en),
    .b_src    (b_src),
    .issue_a  (issue_a),
    .issue_b  (issue_b)
);

// File: tb/dual_issue_pair_tb.sv
`timescale 1ns/1ps
module dual_issue_pair_tb;

    typedef struct packed {
        logic        vld;
        logic [1:0]  kind;
        logic        dst_en;
        logic [3:0]  dst;
        logic [2:0]  sen;
        logic [11:0] src;
    } ins_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        a_vld = 0, b_vld = 0, a_dst_en = 0;
    logic [1:0]  a_kind = 0, b_kind = 0;
    logic [3:0]  a_dst = 0;
    logic [2:0]  a_src_en = 0, b_src_en = 0;
    logic [11:0] a_src = 0, b_src = 0;
    logic        issue_a, issue_b;
    logic [1:0]  issue_cnt;

    int total = 0;
    int bad   = 0;
    bit done  = 0;
    int busy_m [16];
    logic [31:0] seed = 32'h1ACE_B00C;

    always #2.5 clk = ~clk;

    dual_issue_pair u_dut (
        .clk(clk), .rst(rst),
        .a_vld(a_vld), .a_kind(a_kind), .a_dst_en(a_dst_en), .a_dst(a_dst),
        .a_src_en(a_src_en), .a_src(a_src),
        .b_vld(b_vld), .b_kind(b_kind), .b_src_en(b_src_en), .b_src(b_src),
        .issue_a(issue_a), .issue_b(issue_b), .issue_cnt(issue_cnt)
    );

    function automatic ins_t mk(logic v, logic [1:0] k, logic de, logic [3:0] d,
                                logic [2:0] se, logic [3:0] s0, logic [3:0] s1,
                                logic [3:0] s2);
        ins_t x;
        x.vld = v; x.kind = k; x.dst_en = de; x.dst = d;
        x.sen = se; x.src = {s2, s1, s0};
        return x;
    endfunction

    function automatic bit reads(ins_t x, logic [3:0] r);
        bit hit = 0;
        for (int k = 0; k < 3; k++)
            if (x.sen[k] && x.src[k*4 +: 4] == r) hit = 1;
        return hit;
    endfunction

    function automatic bit stalled(ins_t x);
        bit hit = 0;
        for (int k = 0; k < 3; k++)
            if (x.sen[k] && busy_m[x.src[k*4 +: 4]] != 0) hit = 1;
        return hit;
    endfunction

    task automatic check(string tag, string what, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic step(ins_t a, ins_t b, string tag);
        bit ea, eb;
        @(negedge clk);
        a_vld = a.vld; a_kind = a.kind; a_dst_en = a.dst_en; a_dst = a.dst;
        a_src_en = a.sen; a_src = a.src;
        b_vld = b.vld; b_kind = b.kind; b_src_en = b.sen; b_src = b.src;
        #1;
        ea = a.vld && !stalled(a);
        eb = ea && b.vld && a.kind != 2'd3 && b.kind == 2'd3 && !stalled(b)
             && !(a.dst_en && reads(b, a.dst));
        check(tag, "issue_a", int'(issue_a), int'(ea));
        check(tag, "issue_b", int'(issue_b), int'(eb));
        check({tag, " R11"}, "issue_cnt", int'(issue_cnt), int'(ea) + int'(eb));
        for (int r = 0; r < 16; r++) if (busy_m[r] != 0) busy_m[r]--;
        if (ea && a.dst_en && (a.kind == 2'd1 || a.kind == 2'd2)) busy_m[a.dst] = 1;
    endtask

    function automatic logic [31:0] rnd();
        seed ^= seed << 13; seed ^= seed >> 17; seed ^= seed << 5;
        return seed;
    endfunction

    function automatic logic [3:0] pick(logic [1:0] r);
        return {r[1], 2'b00, r[0]};
    endfunction

    ins_t nil;

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        nil = mk(0, 0, 0, 0, 0, 0, 0, 0);
        for (int r = 0; r < 16; r++) busy_m[r] = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;

        // R1 idle and R8 reset state
        step(nil, nil, "R1");
        step(mk(1,0,1,1, 3'b111, 0,2,3), mk(1,3,0,0, 3'b111, 8,9,15), "R8");
        // R5 same-pair RAW, R10 cross-file no conflict
        step(mk(1,0,1,2, 0,0,0,0), mk(1,3,1,9, 3'b001, 2,0,0), "R5");
        step(mk(1,0,1,2, 0,0,0,0), mk(1,3,1,9, 3'b001, 10,0,0), "R10");
        // R4 FP load pairs, then R6 load-use across next pair
        step(mk(1,2,1,11, 0,0,0,0), mk(1,3,1,12, 3'b001, 12,0,0), "R4");
        step(mk(1,0,0,0, 0,0,0,0), mk(1,3,1,13, 3'b010, 0,11,0), "R6");
        step(mk(1,3,1,13, 3'b001, 11,0,0), nil, "R6");
        // R6 integer load then reader stalls, then goes
        step(mk(1,1,1,5, 0,0,0,0), mk(1,3,0,0, 0,0,0,0), "R6");
        step(mk(1,0,1,6, 3'b100, 0,0,5), nil, "R6");
        step(mk(1,0,1,6, 3'b100, 0,0,5), nil, "R6");
        // R3 slot-type mismatches, R2 invalid first
        step(mk(1,3,1,8, 0,0,0,0), mk(1,3,1,9, 0,0,0,0), "R3");
        step(mk(1,0,1,1, 0,0,0,0), mk(1,0,1,2, 0,0,0,0), "R3");
        step(mk(1,3,1,8, 0,0,0,0), mk(1,0,1,2, 0,0,0,0), "R3");
        step(mk(0,0,0,0, 0,0,0,0), mk(1,3,1,9, 0,0,0,0), "R2");
        // R7 disabled source naming a busy register
        step(mk(1,1,1,6, 0,0,0,0), nil, "R7");
        step(mk(1,0,1,7, 3'b010, 6,3,6), nil, "R7");
        // R9 non-load writer does not block next cycle
        step(mk(1,0,1,7, 0,0,0,0), nil, "R9");
        step(mk(1,0,1,1, 3'b001, 7,0,0), nil, "R9");

        // sweep: class pairs x dependence x preceding load
        for (int ka = 0; ka < 4; ka++)
            for (int kb = 0; kb < 4; kb++)
                for (int dep = 0; dep < 2; dep++)
                    for (int pre = 0; pre < 3; pre++) begin
                        logic [3:0] rb, ad;
                        rb = (kb == 3) ? 4'd12 : 4'd4;
                        ad = dep ? rb : 4'd14;
                        if (pre == 1) step(mk(1, rb[3] ? 2'd2 : 2'd1, 1, rb, 0,0,0,0), nil, "R6");
                        else if (pre == 2) step(mk(1,1,1,5, 0,0,0,0), nil, "R6");
                        else step(nil, nil, "R1");
                        step(mk(1, 2'(ka), 1, ad, 3'b010, 0,5,0),
                             mk(1, 2'(kb), 1, 4'd13, 3'b001, rb,0,0),
                             "R1/R2/R3/R5/R6");
                        step(nil, nil, "R1");
                    end

        // pseudo-random pairs on a small register pool
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] w;
            ins_t a, b;
            w = rnd();
            a = mk(w[0] | w[1], w[3:2], w[4], pick(w[6:5]), w[9:7],
                   pick(w[11:10]), pick(w[13:12]), pick(w[15:14]));
            b = mk(w[16] | w[17], w[19:18], w[20], pick(w[22:21]), w[25:23],
                   pick(w[27:26]), pick(w[29:28]), pick(w[31:30]));
            step(a, b, "R1/R2/R3/R5/R6/R7/R10");
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule